// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the write-protection state of a serial NOR flash array. It also answers, for any array address, whether a program or erase to that address has to be refused. The state is a 3-bit range code, a range-end select, a one-way freeze latch and a register write-disable bit. A command decoder outside this block presents status and configuration write data on a single-cycle write strobe. The block accepts the write or drops it, based on the hardware write-protect pin and the freeze latch.

The protected range is a power-of-two fraction of the array, taken from either the top end or the bottom end. The address check is combinational. Its result is ORed with a per-sector lock input from an external sector-protection store. Once the freeze latch is set, it pins the range code and the range-end select, and it refuses every program request aimed at the one-time-programmable area. Only reset clears it.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, `stat_q` and `cfg_q` read 0, and with `sector_lock` low no address is protected.
- R2: The range code is status bits [4:2]. Code 0 protects nothing. Code k in 1..7 protects 2^(k-7) of the 2^ADDR_W byte array, so code 7 protects every address.
- R3: With the range-end select (configuration bit 5) at 0, an address is protected when it is at or above 2^ADDR_W minus the protected size.
- R4: With the range-end select at 1, an address is protected when it is below the protected size, so the range begins at address 0.
- R5: `addr_prot` is the OR of the range result and `sector_lock`.
- R6: The freeze latch is configuration bit 0. Writing it to 1 sets it, and only reset returns it to 0.
- R7: While the freeze latch is 1, an accepted write leaves the range code and the range-end select unchanged and raises no flag. The write-disable bit (status bit 7) is still written.
- R8: `otp_pgm_deny` is high exactly when `otp_pgm_req` is high and the freeze latch is 1.
- R9: While `wp_n` is low and the write-disable bit is 1, a write leaves both registers unchanged. All other status and configuration bits read 0.
- R10: A write accepted on a clock edge changes `stat_q`, `cfg_q` and `addr_prot` from that edge onward. During the cycle in which the write strobe is high, the old values still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wr_stat | input | 8 | Status write data (bit 7 write-disable, bits 4:2 range code) |
| reg_wr_cfg | input | 8 | Configuration write data (bit 5 range-end select, bit 0 freeze) |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| chk_addr | input | ADDR_W | Array address being checked |
| sector_lock | input | 1 | External per-sector protection for the sector of `chk_addr` |
| otp_pgm_req | input | 1 | Program request aimed at the OTP area |
| addr_prot | output | 1 | Address is protected |
| otp_pgm_deny | output | 1 | OTP program request refused |
| stat_q | output | 8 | Status register contents |
| cfg_q | output | 8 | Configuration register contents |

## Verification
A register write and an address check can fall in the same cycle. The bench provokes this by raising the write strobe with a new range code while it holds an address that the new code would protect and the old code would not. It judges the result by sampling `addr_prot` before the capturing edge (old answer expected) and after it (new answer expected). A freeze-setting write and a range-code change can also land in the same write. The bench checks that the code carried by that write is the one that gets locked. It does so by a later write that attempts a different code, followed by a full address sweep.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    localparam int STAT_WD_BIT   = 7;
    localparam int STAT_CODE_LO  = 2;
    localparam int CFG_LOWER_BIT = 5;
    localparam int CFG_FRZ_BIT   = 0;
    localparam int CODE_W        = 3;
    localparam int REG_W         = 8;

    typedef logic [CODE_W-1:0] range_code_t;

    typedef struct packed {
        logic        wd;
        range_code_t code;
        logic        lower;
        logic        frz;
    } prot_state_t;

    function automatic logic [REG_W-1:0] stat_pack(prot_state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[STAT_WD_BIT] = s.wd;
        r[STAT_CODE_LO +: CODE_W] = s.code;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] cfg_pack(prot_state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[CFG_LOWER_BIT] = s.lower;
        r[CFG_FRZ_BIT]   = s.frz;
        return r;
    endfunction

    function automatic prot_state_t regs_unpack(logic [REG_W-1:0] st,
                                                logic [REG_W-1:0] cf);
        prot_state_t s;
        s.wd    = st[STAT_WD_BIT];
        s.code  = st[STAT_CODE_LO +: CODE_W];
        s.lower = cf[CFG_LOWER_BIT];
        s.frz   = cf[CFG_FRZ_BIT];
        return s;
    endfunction

endpackage

// File: rtl/flash_wp_regs.sv
module flash_wp_regs
    import flash_wp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_stat,
    input  logic [REG_W-1:0] wr_cfg,
    input  logic             wp_n,
    output prot_state_t      state
);
    prot_state_t cur_q;
    prot_state_t req;
    prot_state_t nxt;
    logic        pin_lock;
    logic        accept;

    always_comb begin
        req      = regs_unpack(wr_stat, wr_cfg);
        pin_lock = !wp_n && cur_q.wd;
        accept   = wr_en && !pin_lock;
        nxt      = cur_q;
        if (accept) begin
            nxt.wd  = req.wd;
            nxt.frz = cur_q.frz | req.frz;
            if (!cur_q.frz) begin
                nxt.code  = req.code;
                nxt.lower = req.lower;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign state = cur_q;
endmodule

// File: rtl/flash_wp_range.sv
module flash_wp_range
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic [ADDR_W-1:0] addr,
    input  range_code_t       code,
    input  logic              lower,
    output logic              hit
);
    localparam int SPAN_W    = ADDR_W + 1;
    localparam int STEPS     = (1 << CODE_W) - 1;
    localparam int BASE_SH   = ADDR_W - STEPS;
    localparam logic [SPAN_W-1:0] ARRAY_SZ = SPAN_W'(1) << ADDR_W;

    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] addr_x;

    always_comb begin
        span = '0;
        for (int k = 1; k <= STEPS; k++) begin
            if (int'(code) == k) span = SPAN_W'(1) << (BASE_SH + k);
        end
    end

    assign addr_x = {1'b0, addr};

    generate
        if (BASE_SH >= 0) begin : g_ok
            always_comb begin
                if (lower) hit = addr_x < span;
                else       hit = addr_x >= (ARRAY_SZ - span) && (span != '0);
            end
        end else begin : g_tiny
            assign hit = (code != '0);
        end
    endgenerate
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wr_stat,
    input  logic [7:0]        reg_wr_cfg,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              sector_lock,
    input  logic              otp_pgm_req,
    output logic              addr_prot,
    output logic              otp_pgm_deny,
    output logic [7:0]        stat_q,
    output logic [7:0]        cfg_q
);
    prot_state_t st;
    logic        range_hit;

    flash_wp_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_stat (reg_wr_stat),
        .wr_cfg  (reg_wr_cfg),
        .wp_n    (wp_n),
        .state   (st)
    );

    flash_wp_range #(.ADDR_W(ADDR_W)) u_range (
        .addr  (chk_addr),
        .code  (st.code),
        .lower (st.lower),
        .hit   (range_hit)
    );

    assign addr_prot    = range_hit | sector_lock;
    assign otp_pgm_deny = otp_pgm_req & st.frz;
    assign stat_q       = stat_pack(st);
    assign cfg_q        = cfg_pack(st);
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk #(
    parameter int ADDR_W = 26
) (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr_en,
    input logic       wp_n,
    input logic       sector_lock,
    input logic       otp_pgm_req,
    input logic       addr_prot,
    input logic       otp_pgm_deny,
    input logic [7:0] stat_q,
    input logic [7:0] cfg_q
);
    a_r6_freeze_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg_q[0] |=> cfg_q[0]);

    a_r7_frozen_range: assert property (@(posedge clk) disable iff (rst)
        cfg_q[0] |=> ($stable(stat_q[4:2]) && $stable(cfg_q[5])));

    a_r9_pin_lock: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !wp_n && stat_q[7]) |=> ($stable(stat_q) && $stable(cfg_q)));

    a_r8_otp_gate: assert property (@(posedge clk) disable iff (rst)
        (otp_pgm_req && cfg_q[0]) |-> otp_pgm_deny);

    a_r8_otp_open: assert property (@(posedge clk) disable iff (rst)
        !cfg_q[0] |-> !otp_pgm_deny);

    a_r5_sector_or: assert property (@(posedge clk) disable iff (rst)
        sector_lock |-> addr_prot);

    a_r2_all_code: assert property (@(posedge clk) disable iff (rst)
        (stat_q[4:2] == 3'b111) |-> addr_prot);

    a_r2_none_code: assert property (@(posedge clk) disable iff (rst)
        ((stat_q[4:2] == 3'b000) && !sector_lock) |-> !addr_prot);
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_en    (reg_wr_en),
    .wp_n         (wp_n),
    .sector_lock  (sector_lock),
    .otp_pgm_req  (otp_pgm_req),
    .addr_prot    (addr_prot),
    .otp_pgm_deny (otp_pgm_deny),
    .stat_q       (stat_q),
    .cfg_q        (cfg_q)
);

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb;
    localparam int AW = 10;
    localparam int NADDR = 1 << AW;

    logic          clk = 0;
    logic          rst = 1;
    logic          reg_wr_en = 0;
    logic [7:0]    reg_wr_stat = 0;
    logic [7:0]    reg_wr_cfg = 0;
    logic          wp_n = 1;
    logic [AW-1:0] chk_addr = 0;
    logic          sector_lock = 0;
    logic          otp_pgm_req = 0;
    logic          addr_prot, otp_pgm_deny;
    logic [7:0]    stat_q, cfg_q;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    flash_wp_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_stat(reg_wr_stat),
        .reg_wr_cfg(reg_wr_cfg), .wp_n(wp_n), .chk_addr(chk_addr),
        .sector_lock(sector_lock), .otp_pgm_req(otp_pgm_req),
        .addr_prot(addr_prot), .otp_pgm_deny(otp_pgm_deny),
        .stat_q(stat_q), .cfg_q(cfg_q)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_prot(int code, int lower, int a);
        int span;
        span = (code == 0) ? 0 : (NADDR >> (7 - code));
        if (lower != 0) return (a < span) ? 1 : 0;
        return (span != 0 && a >= NADDR - span) ? 1 : 0;
    endfunction

    task automatic wr(logic [7:0] s, logic [7:0] c);
        @(negedge clk);
        reg_wr_stat = s; reg_wr_cfg = c; reg_wr_en = 1;
        @(negedge clk);
        reg_wr_en = 0;
        #1;
    endtask

    task automatic sweep(string req, int code, int lower);
        int mism = 0;
        for (int a = 0; a < NADDR; a++) begin
            chk_addr = AW'(a);
            #1;
            if (int'(addr_prot) != exp_prot(code, lower, a)) begin
                if (mism == 0)
                    chk(req, int'(addr_prot), exp_prot(code, lower, a));
                mism++;
            end
        end
        if (mism == 0) chk(req, 0, 0);
    endtask

    initial begin
        #1_600_000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 stat", stat_q, 0);
        chk("R1 cfg", cfg_q, 0);
        sweep("R1 none", 0, 0);

        // R2 R3 R4 full sweep of codes and both range ends
        for (int lw = 0; lw < 2; lw++) begin
            for (int cd = 0; cd < 8; cd++) begin
                wr(8'(cd << 2), 8'(lw << 5));
                chk("R2 code readback", stat_q, cd << 2);
                chk("R3/R4 end readback", cfg_q, lw << 5);
                sweep(lw != 0 ? "R4 lower range" : "R3 upper range", cd, lw);
            end
        end

        // R5 sector lock OR
        wr(8'(1 << 2), 8'h00);
        sector_lock = 1;
        for (int a = 0; a < NADDR; a += 97) begin
            chk_addr = AW'(a); #1;
            chk("R5 sector or", addr_prot, 1);
        end
        sector_lock = 0;
        chk_addr = 0; #1;
        chk("R5 no lock", addr_prot, 0);

        // R10 write and check in the same cycle
        wr(8'h00, 8'h00);
        @(negedge clk);
        chk_addr = 0;
        reg_wr_stat = 8'(7 << 2); reg_wr_cfg = 8'h00; reg_wr_en = 1;
        #1;
        chk("R10 old value in write cycle", addr_prot, 0);
        @(posedge clk); #1;
        chk("R10 new value after edge", addr_prot, 1);
        chk("R10 stat after edge", stat_q, 7 << 2);
        @(negedge clk); reg_wr_en = 0;

        // R9 pin lock
        wr(8'h80 | 8'(2 << 2), 8'h20);
        chk("R9 wd set", stat_q, 8'h88);
        wp_n = 0;
        wr(8'(6 << 2), 8'h01);
        chk("R9 stat held", stat_q, 8'h88);
        chk("R9 cfg held", cfg_q, 8'h20);
        chk("R8 no freeze via locked write", cfg_q[0], 0);
        wr(8'hFF, 8'hFF);
        chk("R9 other bits stay 0 and held", stat_q, 8'h88);
        wp_n = 1;
        wr(8'(3 << 2), 8'h20);
        chk("R9 write after pin release", stat_q, 3 << 2);

        // R8 OTP before freeze
        otp_pgm_req = 1; #1;
        chk("R8 otp allowed", otp_pgm_deny, 0);

        // R6 R7 freeze in same write as code change
        wr(8'(4 << 2), 8'h21);
        chk("R6 freeze set", cfg_q, 8'h21);
        chk("R7 code taken with freeze", stat_q, 4 << 2);
        chk("R8 otp denied", otp_pgm_deny, 1);
        otp_pgm_req = 0; #1;
        chk("R8 no req no deny", otp_pgm_deny, 0);
        wr(8'h80 | 8'(6 << 2), 8'h00);
        chk("R7 code held, wd written", stat_q, 8'h80 | 8'(4 << 2));
        chk("R6 freeze sticky", cfg_q, 8'h21);
        sweep("R7 frozen range", 4, 1);
        wr(8'h00, 8'h00);
        chk("R7 wd cleared", stat_q, 4 << 2);

        // R6 reset clears freeze
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; #1;
        chk("R6 reset clears cfg", cfg_q, 0);
        chk("R1 reset clears stat", stat_q, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule